// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block translates virtual addresses to physical addresses through a small set-associative cache of page mappings. Each request carries a virtual address, an access kind (load or store) and a privilege level. The set is chosen by low bits of the virtual page number, and every way of that set compares its stored tag at the same time. One cycle later the block returns exactly one of four outcomes: hit, miss, invalid entry or protection violation. On a hit it also returns the physical address and the page attributes.

Software fills entries by itself. It first writes a staged high word that holds the virtual page number and a staged low word that holds the physical page number and the attributes. A load command then copies both into the way named by a replacement pointer. That pointer steps round-robin after every miss, and software may overwrite it to choose a way directly. Page-table walking and exception sequencing belong to the surrounding logic.

Top module: `tlb_sa`

## Requirements
- R1: After reset `rsp_valid` is 0, `way_ptr` is 0, and every entry counts as never loaded, so a lookup before any load reports a miss.
- R2: A request accepted in cycle t produces `rsp_valid`=1 in cycle t+1 with exactly one of `rsp_hit`, `rsp_miss`, `rsp_invalid`, `rsp_prot` set. With no request in cycle t, `rsp_valid` and all four flags are 0 in cycle t+1.
- R3: The set index is VA[16:12] and the tag is VA[31:17]. A tag match in a valid entry that permits the access gives `rsp_hit`, `rsp_pa` = {PPN, VA[11:0]} and `rsp_attr` = {shared, dirty, cacheable, size} (bit 3 down to bit 0).
- R4: When one or more loaded entries of the set match the tag but none of them is valid, the response is `rsp_invalid` and not a hit.
- R5: When no loaded entry of the set matches the tag, the response is `rsp_miss`. On every outcome other than a hit, `rsp_pa` and `rsp_attr` are 0.
- R6: Protection field PR: bit 1 = 1 allows user-level access, bit 0 = 1 allows stores. A valid match with (`req_user` and PR[1]=0) or (`req_store` and PR[0]=0) gives `rsp_prot` and no hit.
- R7: The staged high word holds the VPN in bits [19:0]. The staged low word holds PPN in [26:7], PR in [6:5], size in [4], cacheable in [3], dirty in [2], shared in [1] and valid in [0]. `load_en` writes the staged words as they were before this cycle's staging writes into way `way_ptr` at set VPN[4:0]. A lookup in the same cycle sees the old contents, and lookups from the next cycle on see the new entry.
- R8: Each miss response advances `way_ptr` by one, from WAYS-1 back to 0, and the new value is visible in the same cycle as the miss response. Hit, invalid and protection outcomes and loads leave it unchanged.
- R9: `rc_wr_en` sets `way_ptr` to `rc_wdata` from the next cycle on. A software write has priority over a miss advance in the same cycle.
- R10: When several ways hold a valid match, the lowest-numbered way supplies the result. A valid match in any way takes precedence over an invalid match in another way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load access |
| req_user | input | 1 | 1 = user-level access, 0 = privileged |
| hi_wr_en | input | 1 | Write strobe for the staged high word |
| hi_wdata | input | 20 | Staged VPN value |
| lo_wr_en | input | 1 | Write strobe for the staged low word |
| lo_wdata | input | 27 | Staged PPN and attribute value |
| rc_wr_en | input | 1 | Software write strobe for the replacement pointer |
| rc_wdata | input | 2 | New replacement pointer value |
| load_en | input | 1 | Copy the staged words into the TLB |
| way_ptr | output | 2 | Current replacement pointer |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_miss | output | 1 | No entry matched |
| rsp_invalid | output | 1 | Matching entry not valid |
| rsp_prot | output | 1 | Access kind forbidden by the entry |
| rsp_pa | output | 32 | Physical address on a hit, else 0 |
| rsp_attr | output | 4 | {shared, dirty, cacheable, size} on a hit, else 0 |

## Verification
Lookups are issued against a cold buffer, against single valid and invalid entries, and against duplicate tags spread over several ways. This separates a miss from an invalid match and shows that the lowest way wins. Permission is tried with every pairing of privilege and access kind against each PR value, which tells a protection violation apart from a hit on the same entry. Loads are issued in the same cycle as lookups and staging writes, and pointer writes in the same cycle as misses, which pins down the ordering in R7 and R9. A long random mix drawn from a small pool of page numbers then exercises pointer wrap-around and replacement under load.

// File: rtl/tlb_sa_pkg.sv
package tlb_sa_pkg;

  localparam int VA_W   = 32;
  localparam int PAGE_W = 12;
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int PPN_W  = 20;
  localparam int ATTR_W = 4;

  // Low staged word: PPN, PR, size, cacheable, dirty, shared, valid (MSB first)
  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [1:0]       pr;
    logic             sz;
    logic             c;
    logic             d;
    logic             sh;
    logic             v;
  } tlb_lo_t;

  localparam int LO_W = $bits(tlb_lo_t);

  typedef enum logic [1:0] {
    RES_MISS    = 2'd0,
    RES_HIT     = 2'd1,
    RES_INVALID = 2'd2,
    RES_PROT    = 2'd3
  } tlb_res_e;

  // PR[1]: user access allowed, PR[0]: stores allowed
  function automatic logic pr_forbids(input logic [1:0] pr,
                                      input logic       is_store,
                                      input logic       is_user);
    return (is_user && !pr[1]) || (is_store && !pr[0]);
  endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_sa_pkg::*;
#(
  parameter int SETS  = 32,
  parameter int IDX_W = $clog2(SETS),
  parameter int TAG_W = VPN_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  tlb_lo_t          wr_ent,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             tag_hit,
  output tlb_lo_t          rd_ent
);

  logic [TAG_W-1:0] tag_q [SETS];
  tlb_lo_t          ent_q [SETS];
  logic [SETS-1:0]  vld_q, vld_d;
  logic [SETS-1:0]  used_q, used_d;

  // next-state for the per-set state bits
  always_comb begin
    vld_d  = vld_q;
    used_d = used_q;
    if (wr_en) begin
      vld_d[wr_idx]  = wr_ent.v;
      used_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      used_q <= '0;
    end else begin
      vld_q  <= vld_d;
      used_q <= used_d;
    end
  end

  // payload storage, no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      ent_q[wr_idx] <= wr_ent;
    end
  end

  always_comb begin
    rd_ent   = ent_q[rd_idx];
    rd_ent.v = vld_q[rd_idx];
    tag_hit  = used_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  end

endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_sa_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0]    tag_hit,
  input  tlb_lo_t [WAYS-1:0] ents,
  input  logic               is_store,
  input  logic               is_user,
  output tlb_res_e           res,
  output logic [PPN_W-1:0]   ppn,
  output logic [ATTR_W-1:0]  attr
);

  logic    found;
  tlb_lo_t sel;

  // lowest valid matching way wins: scan from the top down
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (tag_hit[w] && ents[w].v) begin
        found = 1'b1;
        sel   = ents[w];
      end
    end
  end

  always_comb begin
    res  = RES_MISS;
    ppn  = '0;
    attr = '0;
    if (found) begin
      if (pr_forbids(sel.pr, is_store, is_user)) begin
        res = RES_PROT;
      end else begin
        res  = RES_HIT;
        ppn  = sel.ppn;
        attr = {sel.sh, sel.d, sel.c, sel.sz};
      end
    end else if (|tag_hit) begin
      res = RES_INVALID;
    end
  end

endmodule

// File: rtl/tlb_stage.sv
module tlb_stage
  import tlb_sa_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int RC_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_wr_en,
  input  logic [VPN_W-1:0] hi_wdata,
  input  logic             lo_wr_en,
  input  logic [LO_W-1:0]  lo_wdata,
  input  logic             rc_wr_en,
  input  logic [RC_W-1:0]  rc_wdata,
  input  logic             miss_now,
  output logic [VPN_W-1:0] hi_q,
  output tlb_lo_t          lo_q,
  output logic [RC_W-1:0]  rc_q
);

  localparam logic [RC_W-1:0] RC_LAST = RC_W'(WAYS - 1);

  logic [VPN_W-1:0] hi_d;
  tlb_lo_t          lo_d;
  logic [RC_W-1:0]  rc_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    rc_d = rc_q;
    if (hi_wr_en) hi_d = hi_wdata;
    if (lo_wr_en) lo_d = tlb_lo_t'(lo_wdata);
    if (rc_wr_en) begin
      rc_d = rc_wdata;
    end else if (miss_now) begin
      rc_d = (rc_q == RC_LAST) ? '0 : rc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      rc_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      rc_q <= rc_d;
    end
  end

endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
  import tlb_sa_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int RC_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_store,
  input  logic              req_user,
  input  logic              hi_wr_en,
  input  logic [VPN_W-1:0]  hi_wdata,
  input  logic              lo_wr_en,
  input  logic [LO_W-1:0]   lo_wdata,
  input  logic              rc_wr_en,
  input  logic [RC_W-1:0]   rc_wdata,
  input  logic              load_en,
  output logic [RC_W-1:0]   way_ptr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_invalid,
  output logic              rsp_prot,
  output logic [VA_W-1:0]   rsp_pa,
  output logic [ATTR_W-1:0] rsp_attr
);

  logic [VPN_W-1:0]    st_hi;
  tlb_lo_t             st_lo;
  logic [RC_W-1:0]     rc;
  logic                miss_now;

  logic [IDX_W-1:0]    rd_idx;
  logic [TAG_W-1:0]    rd_tag;
  logic [WAYS-1:0]     way_tag_hit;
  tlb_lo_t [WAYS-1:0]  way_ent;

  tlb_res_e            res;
  logic [PPN_W-1:0]    res_ppn;
  logic [ATTR_W-1:0]   res_attr;

  assign rd_idx = req_va[PAGE_W +: IDX_W];
  assign rd_tag = req_va[VA_W-1 -: TAG_W];

  tlb_stage #(.WAYS(WAYS), .RC_W(RC_W)) stage_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_wr_en (hi_wr_en),
    .hi_wdata (hi_wdata),
    .lo_wr_en (lo_wr_en),
    .lo_wdata (lo_wdata),
    .rc_wr_en (rc_wr_en),
    .rc_wdata (rc_wdata),
    .miss_now (miss_now),
    .hi_q     (st_hi),
    .lo_q     (st_lo),
    .rc_q     (rc)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic way_wr;
    assign way_wr = load_en && (rc == RC_W'(w));

    tlb_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) way_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (way_wr),
      .wr_idx  (st_hi[IDX_W-1:0]),
      .wr_tag  (st_hi[VPN_W-1 -: TAG_W]),
      .wr_ent  (st_lo),
      .rd_idx  (rd_idx),
      .rd_tag  (rd_tag),
      .tag_hit (way_tag_hit[w]),
      .rd_ent  (way_ent[w])
    );
  end

  tlb_resolve #(.WAYS(WAYS)) resolve_i (
    .tag_hit  (way_tag_hit),
    .ents     (way_ent),
    .is_store (req_store),
    .is_user  (req_user),
    .res      (res),
    .ppn      (res_ppn),
    .attr     (res_attr)
  );

  assign miss_now = req_valid && (res == RES_MISS);
  assign way_ptr  = rc;

  // response stage
  logic              vld_d, hit_d, miss_d, inv_d, prot_d;
  logic [VA_W-1:0]   pa_d;
  logic [ATTR_W-1:0] attr_d;

  always_comb begin
    vld_d  = req_valid;
    hit_d  = req_valid && (res == RES_HIT);
    miss_d = miss_now;
    inv_d  = req_valid && (res == RES_INVALID);
    prot_d = req_valid && (res == RES_PROT);
    pa_d   = hit_d ? {res_ppn, req_va[PAGE_W-1:0]} : '0;
    attr_d = hit_d ? res_attr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_miss    <= 1'b0;
      rsp_invalid <= 1'b0;
      rsp_prot    <= 1'b0;
      rsp_pa      <= '0;
      rsp_attr    <= '0;
    end else begin
      rsp_valid   <= vld_d;
      rsp_hit     <= hit_d;
      rsp_miss    <= miss_d;
      rsp_invalid <= inv_d;
      rsp_prot    <= prot_d;
      rsp_pa      <= pa_d;
      rsp_attr    <= attr_d;
    end
  end

endmodule

// File: rtl/tlb_sa_chk.sv
module tlb_sa_chk
  import tlb_sa_pkg::*;
#(
  parameter int RC_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [VA_W-1:0]   req_va,
  input logic              rc_wr_en,
  input logic [RC_W-1:0]   way_ptr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              rsp_invalid,
  input logic              rsp_prot,
  input logic [VA_W-1:0]   rsp_pa,
  input logic [ATTR_W-1:0] rsp_attr
);

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_invalid && !rsp_prot);

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_invalid, rsp_prot}) == 1);

  p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_pa[PAGE_W-1:0] == $past(req_va[PAGE_W-1:0])));

  p_zero_on_nohit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && rsp_attr == '0));

  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rc_wr_en) |=> (!rsp_miss || way_ptr == $past(way_ptr) + 1'b1));

  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !rc_wr_en) |=> $stable(way_ptr));

endmodule

bind tlb_sa tlb_sa_chk #(.RC_W(RC_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_va      (req_va),
  .rc_wr_en    (rc_wr_en),
  .way_ptr     (way_ptr),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_miss    (rsp_miss),
  .rsp_invalid (rsp_invalid),
  .rsp_prot    (rsp_prot),
  .rsp_pa      (rsp_pa),
  .rsp_attr    (rsp_attr)
);

// File: tb/tlb_sa_tb_top.sv
`timescale 1ns/1ps
module tlb_sa_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, req_user;
  logic [31:0] req_va;
  logic        hi_wr_en, lo_wr_en, rc_wr_en, load_en;
  logic [19:0] hi_wdata;
  logic [26:0] lo_wdata;
  logic [1:0]  rc_wdata;
  logic [1:0]  way_ptr;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_invalid, rsp_prot;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_attr;

  always #2 clk = ~clk;

  tlb_sa dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_va(req_va), .req_store(req_store), .req_user(req_user),
    .hi_wr_en(hi_wr_en), .hi_wdata(hi_wdata), .lo_wr_en(lo_wr_en), .lo_wdata(lo_wdata),
    .rc_wr_en(rc_wr_en), .rc_wdata(rc_wdata), .load_en(load_en),
    .way_ptr(way_ptr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_invalid(rsp_invalid), .rsp_prot(rsp_prot), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench reference state
  logic [19:0] m_vpn [4][32];
  logic [26:0] m_lo  [4][32];
  bit          m_used[4][32];
  logic [19:0] m_hi;
  logic [26:0] m_lo_st;
  logic [1:0]  m_rc;

  task automatic chk(input bit ok, input string r, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", r, what, act, exp);
    end
  endtask

  function automatic [26:0] mk_lo(input [19:0] ppn, input [1:0] pr, input bit sz,
                                  input bit c, input bit d, input bit sh, input bit v);
    return {ppn, pr, sz, c, d, sh, v};
  endfunction

  // outcome: 0 miss, 1 hit, 2 invalid, 3 protection
  task automatic predict(input [31:0] va, input bit st, input bit us,
                         output int res, output [31:0] pa, output [3:0] attr);
    int idx;
    int sel;
    bit any;
    idx = int'(va[16:12]);
    sel = -1;
    any = 0;
    for (int w = 0; w < 4; w++) begin
      if (m_used[w][idx] && m_vpn[w][idx][19:5] == va[31:17]) begin
        any = 1;
        if (sel < 0 && m_lo[w][idx][0]) sel = w;
      end
    end
    pa = '0;
    attr = '0;
    if (sel >= 0) begin
      logic [26:0] e;
      e = m_lo[sel][idx];
      if ((us && !e[6]) || (st && !e[5])) res = 3;
      else begin
        res = 1;
        pa = {e[26:7], va[11:0]};
        attr = {e[1], e[2], e[3], e[4]};
      end
    end else if (any) res = 2;
    else res = 0;
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_va = '0; req_store = 0; req_user = 0;
    hi_wr_en = 0; hi_wdata = '0; lo_wr_en = 0; lo_wdata = '0;
    rc_wr_en = 0; rc_wdata = '0; load_en = 0;
  endtask

  // one operation cycle followed by the check of its response
  task automatic cyc(input bit rq, input [31:0] va, input bit st, input bit us,
                     input bit ld, input bit hw, input [19:0] hv,
                     input bit lw, input [26:0] lv, input bit rw, input [1:0] rv,
                     input string r);
    int          e_res;
    logic [31:0] e_pa;
    logic [3:0]  e_attr;
    logic [1:0]  e_rc;
    @(negedge clk);
    req_valid = rq; req_va = va; req_store = st; req_user = us;
    load_en = ld; hi_wr_en = hw; hi_wdata = hv; lo_wr_en = lw; lo_wdata = lv;
    rc_wr_en = rw; rc_wdata = rv;
    e_res = 0; e_pa = '0; e_attr = '0;
    if (rq) predict(va, st, us, e_res, e_pa, e_attr);
    if (rw) e_rc = rv;
    else if (rq && e_res == 0) e_rc = m_rc + 2'd1;
    else e_rc = m_rc;
    @(posedge clk);
    if (ld) begin
      m_vpn[m_rc][m_hi[4:0]]  = m_hi;
      m_lo[m_rc][m_hi[4:0]]   = m_lo_st;
      m_used[m_rc][m_hi[4:0]] = 1;
    end
    if (hw) m_hi = hv;
    if (lw) m_lo_st = lv;
    m_rc = e_rc;
    @(negedge clk);
    chk(rsp_valid == rq, r, "rsp_valid", rsp_valid, rq);
    chk(way_ptr == m_rc, r, "way_ptr", way_ptr, m_rc);
    if (rq) begin
      chk({rsp_hit, rsp_miss, rsp_invalid, rsp_prot} ==
          {e_res == 1, e_res == 0, e_res == 2, e_res == 3}, r, "outcome",
          {rsp_hit, rsp_miss, rsp_invalid, rsp_prot},
          {e_res == 1, e_res == 0, e_res == 2, e_res == 3});
      chk(rsp_pa == e_pa, r, "rsp_pa", rsp_pa, e_pa);
      chk(rsp_attr == e_attr, r, "rsp_attr", rsp_attr, e_attr);
    end else begin
      chk({rsp_hit, rsp_miss, rsp_invalid, rsp_prot} == 4'b0, r, "idle flags",
          {rsp_hit, rsp_miss, rsp_invalid, rsp_prot}, 0);
    end
    idle_inputs();
  endtask

  task automatic look(input [31:0] va, input bit st, input bit us, input string r);
    cyc(1, va, st, us, 0, 0, '0, 0, '0, 0, '0, r);
  endtask

  task automatic stage_load(input [19:0] vpn, input [26:0] lo, input [1:0] way, input string r);
    cyc(0, '0, 0, 0, 0, 1, vpn, 1, lo, 1, way, r);
    cyc(0, '0, 0, 0, 1, 0, '0, 0, '0, 0, '0, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 32; s++) begin
        m_used[w][s] = 0; m_vpn[w][s] = '0; m_lo[w][s] = '0;
      end
    m_hi = '0; m_lo_st = '0; m_rc = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1", "reset rsp_valid", rsp_valid, 0);
    chk(way_ptr == 0, "R1", "reset way_ptr", way_ptr, 0);

    // R1 R5 R8: cold lookup misses and steps the pointer
    look(32'h1234_5678, 0, 0, "R1");
    look(32'h0000_0000, 1, 1, "R5");
    cyc(0, '0, 0, 0, 0, 0, '0, 0, '0, 0, '0, "R2");

    // R3 R7 R9: load an entry into way 0, then hit
    stage_load(20'h12345, mk_lo(20'hABCDE, 2'b11, 0, 1, 0, 1, 1), 2'd0, "R9");
    look(32'h1234_5678, 1, 1, "R3");
    look(32'h1234_4FFF, 0, 0, "R5");

    // R4: tag match with valid clear
    stage_load(20'h00045, mk_lo(20'h11111, 2'b11, 1, 1, 1, 1, 0), 2'd1, "R7");
    look(32'h0004_5ABC, 0, 0, "R4");

    // R7: staging write in the load cycle; load uses the older staged words
    cyc(0, '0, 0, 0, 0, 1, 20'h00A07, 1, mk_lo(20'h22222, 2'b11, 0, 0, 1, 0, 1), 1, 2'd2, "R7");
    cyc(0, '0, 0, 0, 1, 1, 20'h00B07, 1, mk_lo(20'h33333, 2'b11, 1, 0, 0, 0, 1), 0, '0, "R7");
    look(32'h00A0_7123, 0, 0, "R7");
    look(32'h00B0_7123, 0, 0, "R7");

    // R7: lookup in the load cycle sees old contents, next cycle sees new
    cyc(1, 32'h00B0_7456, 0, 0, 1, 0, '0, 0, '0, 0, '0, "R7");
    look(32'h00B0_7456, 0, 0, "R7");

    // R6: each privilege and access kind against PR 00 and 10
    stage_load(20'h0C003, mk_lo(20'h44444, 2'b00, 0, 1, 1, 0, 1), 2'd0, "R6");
    look(32'h0C00_3010, 0, 1, "R6");
    look(32'h0C00_3010, 0, 0, "R6");
    look(32'h0C00_3010, 1, 0, "R6");
    stage_load(20'h0D004, mk_lo(20'h55555, 2'b10, 0, 0, 0, 1, 1), 2'd3, "R6");
    look(32'h0D00_4020, 0, 1, "R6");
    look(32'h0D00_4020, 1, 1, "R6");
    look(32'h0D00_4020, 1, 0, "R6");

    // R8: wrap from 3 to 0; hits do not move the pointer
    cyc(0, '0, 0, 0, 0, 0, '0, 0, '0, 1, 2'd3, "R9");
    look(32'hFFFF_F000, 0, 0, "R8");
    look(32'h0D00_4020, 0, 0, "R8");

    // R9: software write beats the miss advance
    cyc(1, 32'hEEEE_E000, 0, 0, 0, 0, '0, 0, '0, 1, 2'd2, "R9");

    // R10: duplicate valid tags, lowest way wins
    stage_load(20'h77708, mk_lo(20'h66661, 2'b11, 0, 0, 0, 0, 1), 2'd2, "R10");
    stage_load(20'h77708, mk_lo(20'h66662, 2'b11, 0, 0, 0, 0, 1), 2'd1, "R10");
    look(32'h7770_8ABC, 0, 0, "R10");
    // invalid in way 0, valid in way 3 on the same tag
    stage_load(20'h8880A, mk_lo(20'h99990, 2'b11, 0, 0, 0, 0, 0), 2'd0, "R10");
    stage_load(20'h8880A, mk_lo(20'h99993, 2'b11, 1, 1, 1, 1, 1), 2'd3, "R10");
    look(32'h8880_A001, 1, 1, "R10");

    // random mix over a small page pool
    begin
      logic [19:0] pool [8];
      void'($urandom(32'd20240607));
      for (int i = 0; i < 8; i++) pool[i] = {$urandom} % 21'h100000;
      pool[1] = {pool[0][19:5], pool[1][4:0]};
      for (int i = 0; i < 3000; i++) begin
        int op;
        logic [19:0] v;
        logic [31:0] va;
        logic [26:0] lo;
        op = int'($urandom % 10);
        v  = pool[$urandom % 8];
        va = {v, 12'({$urandom})};
        if (($urandom % 8) == 0) va = $urandom;
        lo = 27'({$urandom});
        if (($urandom % 5) != 0) lo[0] = 1'b1;
        if (op < 5)
          look(va, 1'($urandom), 1'($urandom), "R3");
        else if (op < 8)
          cyc(1'($urandom), va, 1'($urandom), 1'($urandom), 1'($urandom),
              1, v, 1, lo, 1'($urandom % 4 == 0), 2'($urandom), "R8");
        else
          cyc(1, va, 0, 0, 1, 0, '0, 0, '0, 1'($urandom), 2'($urandom), "R10");
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule